// File: doc/BRIEF.md
# Sprite-Table Copy Bus Arbiter

This block sits between a CPU memory port, a sprite-table copy engine and the two shared memory buses of a small 16-bit address system. A CPU write to the copy-control address latches a source page. From the next cycle the engine copies one byte per cycle from that page into the on-chip sprite table at `$FE00`. While the copy runs, the arbiter decides what each CPU access sees.

High internal RAM answers as normal. The sprite table is locked. A CPU access on the same bus the copy engine is reading from is overridden by the engine's access. An access on the other bus completes normally. When the copy ends, the sprite table opens again on the exact cycle after the last byte is written.

The address map has three parts. Addresses `$8000`–`$9FFF` belong to the video bus. Addresses `$FE00`–`$FFFF` are internal to this block. Every other address belongs to the external bus. The sprite table and high RAM are held inside the block. The two buses are reached through address, read-data, write-data and write-enable ports.

Top module: `spr_dma_arbiter`

## Requirements
- R1: After reset, `dma_active` is 0 and a CPU read of the copy-control address `$FF46` returns `$00`.
- R2: A CPU write of page P to `$FF46` raises `dma_active` on the next cycle. In the k-th active cycle (k from 0), `dma_src` equals P·256+k and `dma_dst` equals `$FE00`+k.
- R3: `dma_active` stays high for exactly 160 cycles. CPU reads of `$FE00`–`$FE9F` return `$FF` up to and including the last active cycle. They return stored data from the following cycle.
- R4: While a copy runs, CPU reads and writes of high RAM (`$FF80`–`$FFFE`) behave exactly as when no copy runs. A written byte is readable in the next cycle.
- R5: While a copy runs, a CPU read on the bus that holds the source page returns the byte at the engine's source address, not the byte at its own address. The engine's address is driven on that bus. Source pages `$80`–`$9F` use the video bus; all other pages use the external bus.
- R6: While a copy runs, a CPU read or write on the other bus uses the CPU's own address and completes normally.
- R7: A CPU write on the bus the copy is using is dropped: that bus's write enable stays 0. The same write made when no copy runs asserts the write enable.
- R8: CPU writes to the sprite table store data when no copy runs. They are ignored while a copy runs.
- R9: After a copy from page P, sprite byte k holds the byte that was read from address P·256+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data returned to the CPU (`$FF` when not reading) |
| ext_addr | output | 16 | External bus address |
| ext_rdata | input | 8 | External bus read data |
| ext_wdata | output | 8 | External bus write data |
| ext_we | output | 1 | External bus write enable |
| vid_addr | output | 16 | Video bus address |
| vid_rdata | input | 8 | Video bus read data |
| vid_wdata | output | 8 | Video bus write data |
| vid_we | output | 1 | Video bus write enable |
| dma_active | output | 1 | Copy in progress |
| dma_src | output | 16 | Current copy source address |
| dma_dst | output | 16 | Current copy destination address |

## Verification
The bench builds the block with its default parameters: a 160-byte table at `$FE00`, the control address at `$FF46` and high RAM from `$FF80` to `$FFFE`. With these values a whole copy fits in one table walk, so the final locked cycle and the first unlocked cycle can both be reached directly. The bus models return a byte derived from the address. A CPU read that was overridden by the copy engine therefore returns a value different from the one at the CPU's own address. The bench runs one copy from an external-bus page and one from a video-bus page, so that each bus is tested both as the conflicting bus and as the free bus.

// File: rtl/spr_dma_arbiter.sv
module spr_dma_arbiter #(
  parameter int          SPR_BYTES = 160,
  parameter logic [15:0] SPR_BASE  = 16'hFE00,
  parameter logic [15:0] CTRL_ADDR = 16'hFF46,
  parameter logic [15:0] HRAM_LO   = 16'hFF80,
  parameter logic [15:0] HRAM_HI   = 16'hFFFE,
  parameter logic [7:0]  LOCK_FILL = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic [15:0] ext_addr,
  input  logic [7:0]  ext_rdata,
  output logic [7:0]  ext_wdata,
  output logic        ext_we,
  output logic [15:0] vid_addr,
  input  logic [7:0]  vid_rdata,
  output logic [7:0]  vid_wdata,
  output logic        vid_we,
  output logic        dma_active,
  output logic [15:0] dma_src,
  output logic [15:0] dma_dst
);
  localparam int IW     = $clog2(SPR_BYTES);
  localparam int HRAM_N = int'(HRAM_HI) - int'(HRAM_LO) + 1;
  localparam int HW     = $clog2(HRAM_N);
  localparam logic [IW-1:0] LAST = IW'(SPR_BYTES - 1);

  typedef enum logic [1:0] {BUS_EXT, BUS_VID, BUS_INT} bus_e;

  logic [IW-1:0] idx;
  logic [7:0]    page;
  logic [7:0]    spr  [SPR_BYTES];
  logic [7:0]    hram [HRAM_N];

  bus_e          cpu_bus;
  logic          dma_vid, ext_busy, vid_busy, start, in_spr, in_hram;
  logic [IW-1:0] spr_off;
  logic [HW-1:0] hram_off;
  logic [7:0]    dma_byte, rd_mux;

  assign cpu_bus  = (cpu_addr[15:13] == 3'b100) ? BUS_VID :
                    (cpu_addr >= SPR_BASE)      ? BUS_INT : BUS_EXT;

  assign dma_src  = {page, 8'(idx)};
  assign dma_dst  = SPR_BASE + 16'(idx);
  assign dma_vid  = (dma_src[15:13] == 3'b100);
  assign ext_busy = dma_active && !dma_vid;
  assign vid_busy = dma_active &&  dma_vid;

  assign ext_addr  = ext_busy ? dma_src : cpu_addr;
  assign vid_addr  = vid_busy ? dma_src : cpu_addr;
  assign ext_wdata = cpu_wdata;
  assign vid_wdata = cpu_wdata;
  assign ext_we    = cpu_wr && (cpu_bus == BUS_EXT) && !ext_busy;
  assign vid_we    = cpu_wr && (cpu_bus == BUS_VID) && !vid_busy;
  assign dma_byte  = dma_vid ? vid_rdata : ext_rdata;

  assign start    = cpu_wr && (cpu_addr == CTRL_ADDR);
  assign in_spr   = (cpu_addr >= SPR_BASE) && (cpu_addr < SPR_BASE + 16'(SPR_BYTES));
  assign in_hram  = (cpu_addr >= HRAM_LO) && (cpu_addr <= HRAM_HI);
  assign spr_off  = IW'(cpu_addr - SPR_BASE);
  assign hram_off = HW'(cpu_addr - HRAM_LO);

  always_comb begin
    rd_mux = LOCK_FILL;
    unique case (cpu_bus)
      BUS_EXT: rd_mux = ext_rdata;
      BUS_VID: rd_mux = vid_rdata;
      BUS_INT: begin
        if (in_hram)                       rd_mux = hram[hram_off];
        else if (cpu_addr == CTRL_ADDR)    rd_mux = page;
        else if (in_spr && !dma_active)    rd_mux = spr[spr_off];
        else                               rd_mux = LOCK_FILL;
      end
      default: rd_mux = LOCK_FILL;
    endcase
  end

  assign cpu_rdata = cpu_rd ? rd_mux : LOCK_FILL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_active <= 1'b0;
      idx        <= '0;
      page       <= '0;
    end else if (start) begin
      dma_active <= 1'b1;
      idx        <= '0;
      page       <= cpu_wdata;
    end else if (dma_active) begin
      idx <= idx + 1'b1;
      if (idx == LAST) dma_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (dma_active)
      spr[idx] <= dma_byte;
    else if (cpu_wr && in_spr)
      spr[spr_off] <= cpu_wdata;
    if (cpu_wr && in_hram)
      hram[hram_off] <= cpu_wdata;
  end
endmodule

// File: rtl/spr_dma_arbiter_chk.sv
module spr_dma_arbiter_chk #(
  parameter int SPR_BYTES = 160
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic [15:0] ext_addr,
  input logic        ext_we,
  input logic [15:0] vid_addr,
  input logic        dma_active,
  input logic [15:0] dma_src
);
  logic start_w, src_vid;
  assign start_w = cpu_wr && (cpu_addr == 16'hFF46);
  assign src_vid = (dma_src[15:13] == 3'b100);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (dma_active && dma_src[7:0] == 8'h00));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && !start_w && dma_src[7:0] != 8'(SPR_BYTES - 1))
      |=> (dma_active && dma_src == $past(dma_src) + 16'd1));

  a_r3_end: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && !start_w && dma_src[7:0] == 8'(SPR_BYTES - 1)) |=> !dma_active);

  a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && cpu_rd && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFE00 + 16'(SPR_BYTES))
      |-> cpu_rdata == 8'hFF);

  a_r5_bus_owner: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> (src_vid ? vid_addr == dma_src : ext_addr == dma_src));

  a_r7_no_drop_leak: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> !(dma_active && !src_vid));
endmodule

bind spr_dma_arbiter spr_dma_arbiter_chk #(.SPR_BYTES(SPR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_rdata(cpu_rdata), .ext_addr(ext_addr), .ext_we(ext_we), .vid_addr(vid_addr),
  .dma_active(dma_active), .dma_src(dma_src)
);

// File: tb/spr_dma_arbiter_tb.sv
module spr_dma_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, ext_rdata, ext_wdata, vid_rdata, vid_wdata;
  logic [15:0] ext_addr, vid_addr, dma_src, dma_dst;
  logic        ext_we, vid_we, dma_active;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] hram_sh [128];

  always #5 clk = ~clk;

  function automatic logic [7:0] extf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] vidf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  assign ext_rdata = extf(ext_addr);
  assign vid_rdata = vidf(vid_addr);

  spr_dma_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ext_addr(ext_addr), .ext_rdata(ext_rdata),
    .ext_wdata(ext_wdata), .ext_we(ext_we), .vid_addr(vid_addr), .vid_rdata(vid_rdata),
    .vid_wdata(vid_wdata), .vid_we(vid_we), .dma_active(dma_active), .dma_src(dma_src),
    .dma_dst(dma_dst)
  );

  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'h2000, 16'hFE10, 16'hFF80, 16'h8123, 16'h0000, 16'hFE9F,
    16'hFFFE, 16'h9FFF, 16'h7FFF, 16'hA000, 16'hFF46, 16'hC555 };

  // model of a CPU read while a copy from page pg is at byte k
  function automatic logic [7:0] model_rd(input logic [15:0] a, input logic [7:0] pg, input int k);
    logic [15:0] s;
    s = {pg, 8'(k)};
    if (a >= 16'hFF80 && a <= 16'hFFFE) return hram_sh[a - 16'hFF80];
    if (a == 16'hFF46) return pg;
    if (a >= 16'hFE00) return 8'hFF;
    if (a[15:13] == 3'b100) return (s[15:13] == 3'b100) ? vidf(s) : vidf(a);
    return (s[15:13] == 3'b100) ? extf(a) : extf(s);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
    if (wr && a >= 16'hFF80 && a <= 16'hFFFE) hram_sh[a - 16'hFF80] = d;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(16'hFF46, 1, 0, 0);
    chk("R1 active", 16'(dma_active), 16'd0);
    chk("R1 ctrl read", 16'(cpu_rdata), 16'h00);

    drive(16'hFF80, 0, 1, 8'h11);
    drive(16'hFFFE, 0, 1, 8'h22);
    drive(16'hFE05, 0, 1, 8'h77);
    drive(16'h4000, 0, 1, 8'h01);
    chk("R7 idle ext write", 16'(ext_we), 16'd1);
    drive(16'hFE05, 1, 0, 0);
    chk("R8 idle sprite write", 16'(cpu_rdata), 16'h77);

    // copy from external page $30
    drive(16'hFF46, 0, 1, 8'h30);
    for (int c = 0; c < 160; c++) begin
      if (c == 20) begin
        drive(16'h4000, 0, 1, 8'hAB);
        chk("R7 dropped ext write", 16'(ext_we), 16'd0);
      end else if (c == 21) begin
        drive(16'h8010, 0, 1, 8'h05);
        chk("R6 free vid write", {vid_we, vid_addr[14:0]}, 16'h8010);
      end else if (c == 22) begin
        drive(16'hFF90, 0, 1, 8'h99);
      end else if (c == 23) begin
        drive(16'hFF90, 1, 0, 0);
        chk("R4 hram rw in copy", 16'(cpu_rdata), 16'h99);
      end else if (c == 158) begin
        drive(16'hFE00, 0, 1, 8'hEE);
      end else if (c == 159) begin
        drive(16'hFE00, 1, 0, 0);
        chk("R3 last cycle locked", 16'(cpu_rdata), 16'hFF);
      end else begin
        drive(VEC[c % NV], 1, 0, 0);
        chk("R4 R5 R6 read", 16'(cpu_rdata), 16'(model_rd(VEC[c % NV], 8'h30, c)));
      end
      chk("R3 active", 16'(dma_active), 16'd1);
      chk("R2 src", dma_src, 16'h3000 + 16'(c));
      chk("R2 dst", dma_dst, 16'hFE00 + 16'(c));
    end
    drive(16'hFE00, 1, 0, 0);
    chk("R3 end", 16'(dma_active), 16'd0);
    chk("R8 ignored write R9", 16'(cpu_rdata), 16'(extf(16'h3000)));
    drive(16'hFE9F, 1, 0, 0);
    chk("R9 last byte", 16'(cpu_rdata), 16'(extf(16'h309F)));
    drive(16'hFE05, 1, 0, 0);
    chk("R9 byte 5", 16'(cpu_rdata), 16'(extf(16'h3005)));

    // copy from video page $81
    drive(16'hFF46, 0, 1, 8'h81);
    for (int c = 0; c < 160; c++) begin
      if (c % 2 == 0) begin
        drive(16'h1234, 1, 0, 0);
        chk("R6 free ext read", 16'(cpu_rdata), 16'(extf(16'h1234)));
      end else begin
        drive(16'h9000, 1, 0, 0);
        chk("R5 vid conflict", 16'(cpu_rdata), 16'(vidf(16'h8100 + 16'(c))));
        chk("R5 vid owner", vid_addr, 16'h8100 + 16'(c));
      end
    end
    drive(16'h4000, 0, 1, 8'h02);
    chk("R7 ext write after vid copy", 16'(ext_we), 16'd1);
    drive(16'hFE50, 1, 0, 0);
    chk("R9 vid copy", 16'(cpu_rdata), 16'(vidf(16'h8150)));
    drive(16'hFFFE, 1, 0, 0);
    chk("R4 hram kept", 16'(cpu_rdata), 16'h22);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule